// File: doc/BRIEF.md
# Dual-Resolution Pulse-Position Modulator

This transmitter turns each 8-bit word into one symbol period on a single serial line. The line is updated once per tick of a fast clock. Every period starts with a reference pulse of fixed width at a fixed place. A single data pulse follows the reference pulse in the same period. The data pulse's rising edge and falling edge are placed independently of each other.

Each edge position is a base offset plus two terms: a coarse step times one 2-bit field, and a fine step times another 2-bit field. A receiver can therefore recover the word with two small time-to-digital stages per edge rather than one wide stage. All steps are whole multiples of the tick.

Words enter through a valid/ready handshake. The block accepts a word only on the last tick of a period and transmits it in the period that follows. When no word is offered, it sends a period carrying code zero.

With the defaults (fine step 1 tick, coarse step 4 ticks, minimum width 4 ticks), the largest modulation span is 15 ticks and the period is 46 ticks.

Top module: `dual_res_ppm_tx`

## Requirements
- R1: While `rst` is high, `line_o` and `in_ready` are low and the tick counter is held at zero. The first tick after `rst` falls is tick 0 of a fresh period, so `line_o` is high one clock after release.
- R2: A period lasts PERIOD = 4·MIN_W + 2·SPAN ticks (46 by default), where SPAN = 3·(COARSE + FINE). `line_o` is high during ticks 0 to MIN_W−1 (the reference pulse). The output lags the tick counter by one clock.
- R3: The rising edge of the data pulse lands on tick 2·MIN_W + COARSE·A + FINE·B. A is `in_word[1:0]` and B is `in_word[3:2]`, both unsigned.
- R4: The falling edge lands on tick 2·MIN_W + SPAN + MIN_W + COARSE·C + FINE·D. C is `in_word[5:4]` and D is `in_word[7:6]`. It does not depend on A or B.
- R5: A set/reset flop forms the data pulse: the rise tick sets it and the fall tick clears it. `line_o` is the reference pulse OR the data pulse and is low on every other tick of the period, including the last one.
- R6: `in_ready` is high only on the final tick of a period. A word offered with `in_valid` on that tick is taken and sent in the very next period.
- R7: `in_valid` on any other tick is ignored. The period in progress is unchanged, and the word waits until the next final tick.
- R8: If `in_valid` is low on the final tick, the next period is sent with code zero: the reference pulse, then a data pulse from tick 2·MIN_W to tick 3·MIN_W + SPAN.
- R9: The coarse step exceeds the whole fine span, so distinct codes give distinct edge ticks. With defaults, A=1,B=0 rises on tick 12 and A=0,B=3 rises on tick 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | High on the final tick of a period, when a word can be taken |
| in_word | input | 8 | Code word: A in [1:0], B in [3:2], C in [5:4], D in [7:6] |
| line_o | output | 1 | Serial output line |

## Verification
The bench aims at both extremes. Code 0x00 puts both edges at their earliest ticks. Code 0xFF pushes the fall to tick 42, which would run into the next reference pulse if the final low gap were sized wrongly. A pair of codes whose fine maximum sits one tick before a coarse step shows whether fine and coarse terms alias or swap field positions. A design that mixes up the fields moves the wrong edge. It then shows up when only the C/D fields change. Words offered in the middle of a period, gaps with no valid word, and a reset in the middle of a data pulse check three more things: that only the boundary accepts a word, that an idle period carries code zero, and that the counter restarts cleanly instead of finishing a stale pulse.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int FIELD_W = 2;
  localparam int WORD_W  = 4 * FIELD_W;

  typedef struct packed {
    logic [FIELD_W-1:0] fall_fine;
    logic [FIELD_W-1:0] fall_coarse;
    logic [FIELD_W-1:0] rise_fine;
    logic [FIELD_W-1:0] rise_coarse;
  } sym_code_t;
endpackage

// File: rtl/dpm_frame_timer.sv
module dpm_frame_timer #(
  parameter int PERIOD = 46,
  parameter int REF_W  = 4,
  parameter int CW     = 6
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          ref_o
);
  localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);
  localparam logic [CW-1:0] REF_C  = CW'(REF_W);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST_C);
  assign ref_o  = (cnt_q < REF_C);

  // R2: the counter wraps to zero exactly after the final tick
  assert_period_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    last_o |=> (cnt_q == '0));
  assert_period_bound_R2: assert property (@(posedge clk) disable iff (rst)
    !last_o |=> (cnt_q != '0));
endmodule

// File: rtl/dpm_code_reg.sv
module dpm_code_reg
  import dpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              last_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ready_o,
  output sym_code_t         code_o
);
  sym_code_t code_q;

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else if (last_i) begin
      if (valid_i) code_q <= sym_code_t'(word_i);
      else         code_q <= '0;
    end
  end

  assign ready_o = last_i;
  assign code_o  = code_q;

  // R6: a word taken at the boundary becomes the next period's code
  assert_accept_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_i && ready_o) |=> (code_q == $past(word_i)));
  // R7: the code never changes away from the boundary
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> $stable(code_q));
  // R8: an empty boundary loads code zero
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !valid_i) |=> (code_q == '0));
endmodule

// File: rtl/dpm_edge_place.sv
module dpm_edge_place #(
  parameter int CW     = 6,
  parameter int FW     = 2,
  parameter int BASE   = 8,
  parameter int COARSE = 4,
  parameter int FINE   = 1
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [FW-1:0] coarse_i,
  input  logic [FW-1:0] fine_i,
  output logic          hit_o
);
  localparam logic [CW-1:0] BASE_C   = CW'(BASE);
  localparam logic [CW-1:0] COARSE_C = CW'(COARSE);
  localparam logic [CW-1:0] FINE_C   = CW'(FINE);
  localparam bit COARSE_POW2 = ((COARSE & (COARSE - 1)) == 0);
  localparam bit FINE_POW2   = ((FINE & (FINE - 1)) == 0);

  logic [CW-1:0] coarse_off;
  logic [CW-1:0] fine_off;

  generate
    if (COARSE_POW2) begin : g_coarse_shift
      assign coarse_off = CW'(coarse_i) << $clog2(COARSE);
    end else begin : g_coarse_mul
      assign coarse_off = COARSE_C * CW'(coarse_i);
    end
    if (FINE_POW2) begin : g_fine_shift
      assign fine_off = CW'(fine_i) << $clog2(FINE);
    end else begin : g_fine_mul
      assign fine_off = FINE_C * CW'(fine_i);
    end
  endgenerate

  assign hit_o = (cnt_i == (BASE_C + coarse_off + fine_off));
endmodule

// File: rtl/dual_res_ppm_tx.sv
module dual_res_ppm_tx
  import dpm_pkg::*;
#(
  parameter int FINE_TICKS   = 1,
  parameter int COARSE_TICKS = 4,
  parameter int MIN_W_TICKS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              line_o
);
  localparam int FIELD_MAX = (1 << FIELD_W) - 1;
  localparam int SPAN      = (COARSE_TICKS + FINE_TICKS) * FIELD_MAX;
  localparam int PERIOD    = 4 * MIN_W_TICKS + 2 * SPAN;
  localparam int RISE_BASE = 2 * MIN_W_TICKS;
  localparam int FALL_BASE = RISE_BASE + SPAN + MIN_W_TICKS;
  localparam int CW        = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt;
  logic          last;
  logic          ref_w;
  sym_code_t     code;
  logic          rise_hit;
  logic          fall_hit;
  logic          data_q;
  logic          line_q;
  logic          data_next;

  dpm_frame_timer #(.PERIOD(PERIOD), .REF_W(MIN_W_TICKS), .CW(CW)) u_timer (
    .clk(clk), .rst(rst), .cnt_o(cnt), .last_o(last), .ref_o(ref_w)
  );

  dpm_code_reg u_code (
    .clk(clk), .rst(rst), .last_i(last), .valid_i(in_valid),
    .word_i(in_word), .ready_o(in_ready), .code_o(code)
  );

  dpm_edge_place #(.CW(CW), .FW(FIELD_W), .BASE(RISE_BASE),
                   .COARSE(COARSE_TICKS), .FINE(FINE_TICKS)) u_rise (
    .cnt_i(cnt), .coarse_i(code.rise_coarse), .fine_i(code.rise_fine),
    .hit_o(rise_hit)
  );

  dpm_edge_place #(.CW(CW), .FW(FIELD_W), .BASE(FALL_BASE),
                   .COARSE(COARSE_TICKS), .FINE(FINE_TICKS)) u_fall (
    .cnt_i(cnt), .coarse_i(code.fall_coarse), .fine_i(code.fall_fine),
    .hit_o(fall_hit)
  );

  // set/reset flop: rise event sets, fall event clears
  assign data_next = rise_hit | (data_q & ~fall_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= 1'b0;
      line_q <= 1'b0;
    end else begin
      data_q <= data_next;
      line_q <= ref_w | data_next;
    end
  end

  assign line_o = line_q;

  // R2: output is high on the clocks carrying reference ticks
  assert_ref_high_R2: assert property (@(posedge clk) disable iff (rst)
    ((cnt != '0) && (cnt <= CW'(MIN_W_TICKS))) |-> line_o);
  // R3: data pulse only starts on the placed rising tick
  assert_rise_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(data_q) |-> $past(rise_hit));
  // R4: data pulse only ends on the placed falling tick
  assert_fall_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(data_q) |-> $past(fall_hit));
  // R5: reference and data pulses never overlap
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    data_q |-> !ref_w);
  // R9: the two edges are never due on the same tick
  assert_edges_apart_R9: assert property (@(posedge clk) disable iff (rst)
    !(rise_hit && fall_hit));
endmodule

// File: tb/dual_res_ppm_tx_test.sv
module dual_res_ppm_tx_test;
  localparam int FT = 1, CT = 4, MW = 4;
  localparam int SPAN = (CT + FT) * 3;
  localparam int PER = 4 * MW + 2 * SPAN;
  localparam int RB = 2 * MW;
  localparam int FB = RB + SPAN + MW;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_word = 8'h00;
  logic       in_ready;
  logic       line_o;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dual_res_ppm_tx uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .line_o(line_o)
  );

  function automatic int rise_of(logic [7:0] c);
    return RB + CT * int'(c[1:0]) + FT * int'(c[3:2]);
  endfunction
  function automatic int fall_of(logic [7:0] c);
    return FB + CT * int'(c[5:4]) + FT * int'(c[7:6]);
  endfunction
  function automatic logic pat(int k, logic [7:0] c);
    return (k < MW) || (k >= rise_of(c) && k < fall_of(c));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // entry: at a negedge with in_ready high; exit: same state one period later
  task automatic run_period(bit drv, logic [7:0] w, logic [7:0] exp_c,
                            string req, int late_at, logic [7:0] late_w);
    int bad = -1;
    int rdy_bad = -1;
    int r_seen = -1;
    int f_seen = -1;
    in_valid = drv;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    check(line_o == 1'b0, "R5", "line on final tick", int'(line_o), 0);
    for (int k = 0; k < PER - 1; k++) begin
      if (k == late_at) begin
        in_valid = 1'b1;
        in_word  = late_w;
      end
      @(negedge clk);
      if (line_o !== pat(k, exp_c) && bad < 0) bad = k;
      if (in_ready !== (k == PER - 2) && rdy_bad < 0) rdy_bad = k;
      if (k >= MW && r_seen < 0 && line_o === 1'b1) r_seen = k;
      if (r_seen >= 0 && f_seen < 0 && line_o === 1'b0) f_seen = k;
    end
    check(bad < 0, req, "first wrong tick of period", bad, -1);
    check(r_seen == rise_of(exp_c), "R3", "rise tick", r_seen, rise_of(exp_c));
    check(f_seen == fall_of(exp_c), "R4", "fall tick", f_seen, fall_of(exp_c));
    check(rdy_bad < 0, "R6", "ready only on final tick, bad at", rdy_bad, -1);
  endtask

  task automatic align(string req);
    int n = 0;
    @(negedge clk);
    check(line_o == 1'b1, "R1", "line one clock after release", int'(line_o), 1);
    n = 1;
    while (!in_ready && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n == PER - 1, req, "clocks from release to first boundary", n, PER - 1);
  endtask

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(line_o == 1'b0, "R1", "line in reset", int'(line_o), 0);
    check(in_ready == 1'b0, "R1", "ready in reset", int'(in_ready), 0);
    rst = 1'b0;
    align("R2");

    // R8: idle period carries code zero
    run_period(1'b0, 8'h00, 8'h00, "R8", -1, 8'h00);
    // extremes of both edges
    run_period(1'b1, 8'hFF, 8'hFF, "R4", -1, 8'h00);
    run_period(1'b1, 8'h00, 8'h00, "R3", -1, 8'h00);
    // R9: coarse vs fine aliasing pair
    run_period(1'b1, 8'h01, 8'h01, "R9", -1, 8'h00);
    run_period(1'b1, 8'h0C, 8'h0C, "R9", -1, 8'h00);
    // R4: fall fields alone move only the falling edge
    run_period(1'b1, 8'h30, 8'h30, "R4", -1, 8'h00);
    run_period(1'b1, 8'hC0, 8'hC0, "R4", -1, 8'h00);
    // R7: word raised mid-period does not change the current period
    run_period(1'b0, 8'h00, 8'h00, "R7", 10, 8'hA5);
    run_period(1'b1, 8'hA5, 8'hA5, "R7", -1, 8'h00);
    // R6: back-to-back words
    run_period(1'b1, 8'h5A, 8'h5A, "R6", -1, 8'h00);
    run_period(1'b1, 8'h96, 8'h96, "R6", -1, 8'h00);

    // R1: reset in the middle of a data pulse
    repeat (15) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(line_o == 1'b0, "R1", "line after mid-pulse reset", int'(line_o), 0);
    check(in_ready == 1'b0, "R1", "ready after mid-pulse reset", int'(in_ready), 0);
    @(negedge clk);
    rst = 1'b0;
    align("R1");

    for (int i = 0; i < 40; i++) begin
      logic [7:0] w;
      bit drv;
      w   = 8'($urandom);
      drv = ($urandom % 4) != 0;
      run_period(drv, w, drv ? w : 8'h00, drv ? "R5" : "R8", -1, 8'h00);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule